// File: doc/BRIEF.md
# Multi-mode pin wakeup detector

This block watches a set of already-selected pin levels, one per detector, and raises a wakeup request when any of them shows a configured event. Each detector has an enable bit, a 3-bit mode and a threshold. Two of the modes count pulse length. A detector that fires sets a sticky cause bit. The OR of all cause bits drives the wakeup request.

Software reads the cause bits on `cause_o`. It clears them with a one-cycle write strobe and a per-bit clear mask. A write takes priority over every detection in the same cycle. A detection made in cycle t is visible on `cause_o` and `wkup_req_o` after the clock edge that ends cycle t.

Every control and status pin is a plain level. No data streams through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pin_wakeup_detector`

## Requirements
- R1: Mode 3'd0 (rising) fires in a cycle where the pin is 1 and its previous sample was 0. The previous sample is tracked whether or not the detector is enabled, and it reads as low right after reset.
- R2: Mode 3'd1 (falling) fires in a cycle where the pin is 0 and its previous sample was 1.
- R3: Mode 3'd2 (either edge) fires in any cycle where the pin differs from its previous sample.
- R4: Mode 3'd3 (timed high) fires in the cycle where the pin has been high for exactly threshold+1 consecutive samples, counting the sample that changed level.
- R5: Mode 3'd4 (timed low) fires in the cycle where the pin has been low for exactly threshold+1 consecutive samples.
- R6: A timed mode fires at most once per pulse. The run counter is one bit wider than the threshold and saturates rather than wrapping, so a very long pulse never fires again.
- R7: The run count restarts when the pin changes level, and also when the detector is disabled. After re-enabling, the current level counts from one.
- R8: A detection sets that detector's cause bit, and the bit stays set. In a cycle with `cause_wr_i`=1, each cause bit whose `cause_wdata_i` bit is 1 is cleared, and no cause bit is set by any detection that cycle.
- R9: `wkup_req_o` is 1 whenever any cause bit is 1, and 0 only when all of them are 0.
- R10: A disabled detector never fires, and mode values 3'd5 to 3'd7 never fire.
- R11: Reset (`rst_ni` low, asynchronous) clears all cause bits, run counters and pin history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_DET | Selected pin level per detector |
| det_en_i | input | NUM_DET | Per-detector enable |
| det_mode_i | input | 3*NUM_DET | Mode of detector i at bits [3i+2:3i] |
| det_thresh_i | input | THR_W*NUM_DET | Threshold of detector i at bits [THR_W*i +: THR_W] |
| cause_wr_i | input | 1 | Software write strobe to the cause bits |
| cause_wdata_i | input | NUM_DET | Clear mask, 1 clears that cause bit |
| cause_o | output | NUM_DET | Sticky cause bits |
| wkup_req_o | output | 1 | OR of all cause bits |

## Verification
The bench builds the block with NUM_DET=4 and THR_W=4. Four detectors let rising, falling, either-edge and timed modes run side by side in one vector walk. The 4-bit threshold lets a maximal threshold of 15 be held for long enough that the 5-bit run counter saturates at 31; a wrapping counter would come back round to 16 after 48 samples and fire again. With the small width, both the single-fire rule and the no-wrap rule can be checked in under a hundred cycles.

// File: rtl/wkd_pkg.sv
package wkd_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    WK_RISE = 3'd0,
    WK_FALL = 3'd1,
    WK_BOTH = 3'd2,
    WK_HIGH = 3'd3,
    WK_LOW  = 3'd4
  } wk_mode_e;
endpackage

// File: rtl/wkd_run_counter.sv
module wkd_run_counter #(
  parameter int unsigned THR_W = 8,
  localparam int unsigned RUN_W = THR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             changed_i,
  output logic [RUN_W-1:0] run_o,
  output logic             stepped_o
);
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
  localparam logic [RUN_W-1:0] RUN_ONE = {{(RUN_W-1){1'b0}}, 1'b1};

  logic [RUN_W-1:0] cnt_q;

  // Length of the current level run, this sample included.
  always_comb begin
    if (changed_i) begin
      run_o     = RUN_ONE;
      stepped_o = 1'b1;
    end else if (cnt_q == RUN_MAX) begin
      run_o     = RUN_MAX;
      stepped_o = 1'b0;
    end else begin
      run_o     = cnt_q + RUN_ONE;
      stepped_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= run_o;
  end
endmodule

// File: rtl/wkd_detector.sv
module wkd_detector
  import wkd_pkg::*;
#(
  parameter int unsigned THR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [THR_W-1:0]  thresh_i,
  output logic              hit_o
);
  localparam int unsigned RUN_W = THR_W + 1;

  logic             pin_q;
  logic             changed;
  logic [RUN_W-1:0] run;
  logic             stepped;
  logic [RUN_W-1:0] target;
  logic             timed_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_i;
  end

  assign changed = pin_i ^ pin_q;

  wkd_run_counter #(.THR_W(THR_W)) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .changed_i (changed),
    .run_o     (run),
    .stepped_o (stepped)
  );

  assign target    = {1'b0, thresh_i} + {{(RUN_W-1){1'b0}}, 1'b1};
  assign timed_hit = stepped && (run == target);

  always_comb begin
    hit_o = 1'b0;
    if (en_i) begin
      case (mode_i)
        WK_RISE: hit_o = pin_i & ~pin_q;
        WK_FALL: hit_o = ~pin_i & pin_q;
        WK_BOTH: hit_o = changed;
        WK_HIGH: hit_o = pin_i & timed_hit;
        WK_LOW:  hit_o = ~pin_i & timed_hit;
        default: hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/wkd_cause_bank.sv
module wkd_cause_bank #(
  parameter int unsigned NUM_DET = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DET-1:0] hit_i,
  input  logic               wr_i,
  input  logic [NUM_DET-1:0] wdata_i,
  output logic [NUM_DET-1:0] cause_o
);
  logic [NUM_DET-1:0] cause_q;

  // A software write wins over every detection in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cause_q <= '0;
    else if (wr_i) cause_q <= cause_q & ~wdata_i;
    else           cause_q <= cause_q | hit_i;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/pin_wakeup_detector.sv
module pin_wakeup_detector
  import wkd_pkg::*;
#(
  parameter int unsigned NUM_DET = 4,
  parameter int unsigned THR_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_DET-1:0]         pin_i,
  input  logic [NUM_DET-1:0]         det_en_i,
  input  logic [MODE_W*NUM_DET-1:0]  det_mode_i,
  input  logic [THR_W*NUM_DET-1:0]   det_thresh_i,
  input  logic                       cause_wr_i,
  input  logic [NUM_DET-1:0]         cause_wdata_i,
  output logic [NUM_DET-1:0]         cause_o,
  output logic                       wkup_req_o
);
  logic [NUM_DET-1:0] hit;

  for (genvar g = 0; g < NUM_DET; g++) begin : g_det
    wkd_detector #(.THR_W(THR_W)) u_det (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pin_i[g]),
      .en_i     (det_en_i[g]),
      .mode_i   (det_mode_i[MODE_W*g +: MODE_W]),
      .thresh_i (det_thresh_i[THR_W*g +: THR_W]),
      .hit_o    (hit[g])
    );
  end

  wkd_cause_bank #(.NUM_DET(NUM_DET)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .wr_i    (cause_wr_i),
    .wdata_i (cause_wdata_i),
    .cause_o (cause_o)
  );

  assign wkup_req_o = |cause_o;
endmodule

// File: rtl/wkd_checker.sv
module wkd_checker #(
  parameter int unsigned NUM_DET = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_DET-1:0]   pin_i,
  input logic [NUM_DET-1:0]   det_en_i,
  input logic [3*NUM_DET-1:0] det_mode_i,
  input logic                 cause_wr_i,
  input logic [NUM_DET-1:0]   cause_wdata_i,
  input logic [NUM_DET-1:0]   cause_o,
  input logic                 wkup_req_o
);
  logic [NUM_DET-1:0] chk_pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_pin_q <= '0;
    else         chk_pin_q <= pin_i;
  end

  // R9
  p_req_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o != '0) |-> wkup_req_o);
  p_req_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o == '0) |-> !wkup_req_o);

  // R8
  p_write_no_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_wr_i |=> ((cause_o & ~$past(cause_o)) == '0));
  p_write_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_wr_i |=> ((cause_o & $past(cause_wdata_i)) == '0));
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cause_wr_i |=> (($past(cause_o) & ~cause_o) == '0));

  // R10
  p_disabled_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(det_en_i)) == '0));

  for (genvar g = 0; g < NUM_DET; g++) begin : g_chk
    // R1
    p_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (det_en_i[g] && det_mode_i[3*g +: 3] == 3'd0 && !cause_wr_i &&
       pin_i[g] && !chk_pin_q[g]) |=> cause_o[g]);
    // R2
    p_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (det_en_i[g] && det_mode_i[3*g +: 3] == 3'd1 && !cause_wr_i &&
       !pin_i[g] && chk_pin_q[g]) |=> cause_o[g]);
    // R3
    p_both_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (det_en_i[g] && det_mode_i[3*g +: 3] == 3'd2 && !cause_wr_i &&
       (pin_i[g] != chk_pin_q[g])) |=> cause_o[g]);
    // R10
    p_bad_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (det_mode_i[3*g +: 3] >= 3'd5 && !cause_o[g]) |=> !cause_o[g]);
  end
endmodule

bind pin_wakeup_detector wkd_checker #(.NUM_DET(NUM_DET)) u_wkd_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pin_i         (pin_i),
  .det_en_i      (det_en_i),
  .det_mode_i    (det_mode_i),
  .cause_wr_i    (cause_wr_i),
  .cause_wdata_i (cause_wdata_i),
  .cause_o       (cause_o),
  .wkup_req_o    (wkup_req_o)
);

// File: tb/pin_wakeup_detector_bench.sv
module pin_wakeup_detector_bench;
  localparam int unsigned N  = 4;
  localparam int unsigned TW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    pin = '0;
  logic [N-1:0]    en = '0;
  logic [3*N-1:0]  mode = '0;
  logic [TW*N-1:0] thr = '0;
  logic            wr = 1'b0;
  logic [N-1:0]    wdata = '0;
  logic [N-1:0]    cause;
  logic            req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pin_wakeup_detector #(.NUM_DET(N), .THR_W(TW)) u_pin_wakeup_detector (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .det_en_i(en),
    .det_mode_i(mode), .det_thresh_i(thr), .cause_wr_i(wr),
    .cause_wdata_i(wdata), .cause_o(cause), .wkup_req_o(req)
  );

  // Row fields: pins[12:9], wr[8], wdata[7:4], expected cause[3:0]
  localparam int NV = 15;
  localparam logic [12:0] VEC [NV] = '{
    {4'b0000, 1'b0, 4'b0000, 4'b0000},
    {4'b1111, 1'b0, 4'b0000, 4'b0101},
    {4'b1111, 1'b0, 4'b0000, 4'b0101},
    {4'b1111, 1'b0, 4'b0000, 4'b1101},
    {4'b1111, 1'b1, 4'b1111, 4'b0000},
    {4'b1111, 1'b0, 4'b0000, 4'b0000},
    {4'b0000, 1'b0, 4'b0000, 4'b0110},
    {4'b0000, 1'b1, 4'b0010, 4'b0100},
    {4'b1111, 1'b1, 4'b0000, 4'b0100},
    {4'b1111, 1'b0, 4'b0000, 4'b0100},
    {4'b0111, 1'b0, 4'b0000, 4'b0100},
    {4'b1111, 1'b0, 4'b0000, 4'b0100},
    {4'b1111, 1'b0, 4'b0000, 4'b0100},
    {4'b1111, 1'b0, 4'b0000, 4'b1100},
    {4'b0000, 1'b1, 4'b1111, 4'b0000}
  };

  task automatic chk(input string req_tag, input logic [N-1:0] got,
                     input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req_tag, got, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic [N-1:0] p, input logic w, input logic [N-1:0] wd);
    pin = p; wr = w; wdata = wd;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // det0 rising, det1 falling, det2 either edge, det3 timed high thr 2
    mode = {3'd3, 3'd2, 3'd1, 3'd0};
    thr  = {4'd2, 4'd0, 4'd0, 4'd0};
    en   = 4'b1111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 reset cause", cause, 4'b0000);
    chk("R11 reset req", {3'b0, req}, 4'b0000);

    // Vector walk: R1 R2 R3 R4 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][12:9], VEC[i][8], VEC[i][7:4]);
      chk($sformatf("R1-R4/R8 row %0d cause", i), cause, VEC[i][3:0]);
      chk($sformatf("R9 row %0d req", i), {3'b0, req}, {3'b0, |VEC[i][3:0]});
    end

    // R5: timed low, threshold 0, only det3 enabled
    mode[11:9] = 3'd4; thr[15:12] = 4'd0; en = 4'b1000;
    step(4'b1000, 1'b0, '0);
    chk("R5 high sample no fire", cause, 4'b0000);
    step(4'b0000, 1'b0, '0);
    chk("R5 low for one sample fires", cause, 4'b1000);
    chk("R9 req after timed low", {3'b0, req}, 4'b0001);
    step(4'b0000, 1'b1, 4'b1000);
    step(4'b0000, 1'b0, '0);
    chk("R5 one fire per low pulse", cause, 4'b0000);

    // R10: reserved modes enabled, det3 disabled in either-edge mode
    mode = {3'd2, 3'd7, 3'd6, 3'd5}; en = 4'b0111;
    for (int k = 0; k < 6; k++) step((k % 2 == 0) ? 4'b1111 : 4'b0000, 1'b0, '0);
    chk("R10 reserved modes and disabled never fire", cause, 4'b0000);
    chk("R10 req quiet", {3'b0, req}, 4'b0000);

    // R6: maximal threshold, long pulse, saturating run counter
    mode[11:9] = 3'd3; thr[15:12] = 4'd15; en = 4'b1000;
    step(4'b0000, 1'b0, '0);
    for (int k = 0; k < 15; k++) step(4'b1000, 1'b0, '0);
    chk("R6 fifteen high samples no fire", cause, 4'b0000);
    step(4'b1000, 1'b0, '0);
    chk("R6 sixteenth high sample fires", cause, 4'b1000);
    step(4'b1000, 1'b1, 4'b1000);
    for (int k = 0; k < 50; k++) step(4'b1000, 1'b0, '0);
    chk("R6 no refire without wrap", cause, 4'b0000);

    // R7: disabling restarts the run count
    thr[15:12] = 4'd3;
    en = 4'b0000;
    step(4'b1000, 1'b0, '0);
    en = 4'b1000;
    for (int k = 0; k < 3; k++) step(4'b1000, 1'b0, '0);
    chk("R7 three samples after re-enable", cause, 4'b0000);
    step(4'b1000, 1'b0, '0);
    chk("R7 fourth sample after re-enable fires", cause, 4'b1000);

    // R11: asynchronous reset clears a set cause
    #2 rst_n = 1'b0;
    #1;
    chk("R11 async reset clears cause", cause, 4'b0000);
    chk("R11 async reset clears req", {3'b0, req}, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    finish_run();
  end
endmodule